// File: doc/BRIEF.md
# Mode-Selected Rotating Light Pattern

This block drives a row of lights where exactly one light is lit at a time. A 2-bit mode input is sampled on every rising clock edge. Depending on the mode, the lit light returns to the lowest position, steps one place toward the top, steps one place toward the bottom, or stays where it is. Stepping past either end wraps around to the other end.

Internally the lit position is stored as a small binary index. Separate combinational logic decodes that index into a one-hot light vector, so the output only changes as a result of a clock edge. The block has no reset pin. Returning to the lowest position is one of the four modes, and it must be selected once before the output is meaningful.

Top module: `rotating_lights`

## Requirements
- R1: Mode 2 (`sel = 2'b10`) at a rising edge sets the position to 0, so the output becomes 1 in bit 0 only (`4'b0001`).
- R2: Mode 1 (`sel = 2'b01`) at a rising edge moves the lit bit one place toward the MSB (position + 1).
- R3: In mode 1, a lit bit at the top position (bit 3) moves to bit 0.
- R4: Mode 0 (`sel = 2'b00`) at a rising edge moves the lit bit one place toward the LSB (position − 1).
- R5: In mode 0, a lit bit at bit 0 moves to the top position (bit 3).
- R6: Mode 3 (`sel = 2'b11`) at a rising edge leaves the output unchanged.
- R7: After the first mode-2 edge, exactly one output bit is set at all times, and position p drives bit p.
- R8: A change on `sel` between clock edges has no effect on the output until the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the mode is acted on at the rising edge |
| sel | input | 2 | Mode: 0 step down, 1 step up, 2 go to position 0, 3 hold |
| lights | output | NUM_LIGHTS (4) | One-hot light vector decoded from the position |

## Verification
The bench builds the block with the default of four lights, which makes the position space only four states wide. At that size, every pairing of starting position and mode can be driven directly, so both wrap-arounds and hold at each position are covered. A long deterministic pseudo-random mode sequence then runs against an arithmetic position model. Every step also changes `sel` mid-cycle to confirm that the output does not move before the edge.

// File: rtl/lights_pkg.sv
package lights_pkg;

  typedef enum logic [1:0] {
    MODE_DOWN  = 2'd0,
    MODE_UP    = 2'd1,
    MODE_CLEAR = 2'd2,
    MODE_HOLD  = 2'd3
  } lightMode_e;

  // Strobes from control to datapath; at most one is set per cycle.
  typedef struct packed {
    logic clear;
    logic stepUp;
    logic stepDown;
  } stepStrobes_t;

endpackage

// File: rtl/light_ctrl.sv
module light_ctrl
  import lights_pkg::*;
(
  input  logic [1:0]   sel,
  output stepStrobes_t strobes
);

  lightMode_e mode;

  always_comb begin
    mode    = lightMode_e'(sel);
    strobes = '0;
    unique case (mode)
      MODE_CLEAR: strobes.clear    = 1'b1;
      MODE_UP:    strobes.stepUp   = 1'b1;
      MODE_DOWN:  strobes.stepDown = 1'b1;
      MODE_HOLD:  strobes          = '0;
    endcase
  end

endmodule

// File: rtl/light_datapath.sv
module light_datapath
  import lights_pkg::*;
#(
  parameter int NUM_LIGHTS = 4
) (
  input  logic                  clk,
  input  stepStrobes_t          strobes,
  output logic [NUM_LIGHTS-1:0] lights
);

  localparam int POS_W = (NUM_LIGHTS > 1) ? $clog2(NUM_LIGHTS) : 1;
  localparam logic [POS_W-1:0] POS_LAST = POS_W'(NUM_LIGHTS - 1);

  logic [POS_W-1:0] posQ;
  logic [POS_W-1:0] posUp;
  logic [POS_W-1:0] posDown;

  // Wrap explicitly so a count that is not a power of two still cycles.
  always_comb begin
    posUp   = (posQ == POS_LAST) ? '0 : posQ + 1'b1;
    posDown = (posQ == '0) ? POS_LAST : posQ - 1'b1;
  end

  always_ff @(posedge clk) begin
    case (1'b1)
      strobes.clear:    posQ <= '0;
      strobes.stepUp:   posQ <= posUp;
      strobes.stepDown: posQ <= posDown;
      default:          posQ <= posQ;
    endcase
  end

  // Index-to-one-hot decode, one comparator per light.
  genvar gi;
  generate
    for (gi = 0; gi < NUM_LIGHTS; gi++) begin : g_decode
      assign lights[gi] = (posQ == POS_W'(gi));
    end
  endgenerate

endmodule

// File: rtl/rotating_lights.sv
module rotating_lights
  import lights_pkg::*;
#(
  parameter int NUM_LIGHTS = 4
) (
  input  logic                  clk,
  input  logic [1:0]            sel,
  output logic [NUM_LIGHTS-1:0] lights
);

  stepStrobes_t strobes;

  light_ctrl u_ctrl (
    .sel     (sel),
    .strobes (strobes)
  );

  light_datapath #(.NUM_LIGHTS(NUM_LIGHTS)) u_dp (
    .clk     (clk),
    .strobes (strobes),
    .lights  (lights)
  );

endmodule

// File: rtl/light_checker.sv
module light_checker #(
  parameter int NUM_LIGHTS = 4
) (
  input logic                  clk,
  input logic [1:0]            sel,
  input logic [NUM_LIGHTS-1:0] lights
);

  // The position is unknown until the first clear; checks start after it.
  logic armed = 1'b0;

  always_ff @(posedge clk) begin
    if (sel == 2'd2) armed <= 1'b1;
  end

  AST_CLEAR_TO_ZERO: assert property (@(posedge clk) disable iff (!armed)
    sel == 2'd2 |=> lights == NUM_LIGHTS'(1)); // R1

  AST_STEP_UP: assert property (@(posedge clk) disable iff (!armed)
    sel == 2'd1 |=> lights == {$past(lights[NUM_LIGHTS-2:0]), $past(lights[NUM_LIGHTS-1])}); // R2

  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!armed)
    sel == 2'd0 |=> lights == {$past(lights[0]), $past(lights[NUM_LIGHTS-1:1])}); // R4

  AST_HOLD_STILL: assert property (@(posedge clk) disable iff (!armed)
    sel == 2'd3 |=> $stable(lights)); // R6

  AST_ONE_LIT: assert property (@(posedge clk) disable iff (!armed)
    $countones(lights) == 1); // R7

  AST_TOP_WRAP: assert property (@(posedge clk) disable iff (!armed)
    (sel == 2'd1 && lights[NUM_LIGHTS-1]) |=> lights[0]); // R3

  AST_BOTTOM_WRAP: assert property (@(posedge clk) disable iff (!armed)
    (sel == 2'd0 && lights[0]) |=> lights[NUM_LIGHTS-1]); // R5

endmodule

bind rotating_lights light_checker #(.NUM_LIGHTS(NUM_LIGHTS)) u_chk (
  .clk    (clk),
  .sel    (sel),
  .lights (lights)
);

// File: tb/tb_rotating_lights.sv
module tb_rotating_lights;

  localparam int N = 4;

  logic         clk = 1'b0;
  logic [1:0]   sel = 2'd2;
  logic [N-1:0] lights;

  int testsRun = 0;
  int testsFailed = 0;
  int pos = 0;
  bit finished = 0;

  rotating_lights #(.NUM_LIGHTS(N)) dut (
    .clk    (clk),
    .sel    (sel),
    .lights (lights)
  );

  always #4 clk = ~clk;  // 8 ns period, 125 MHz

  function automatic logic [N-1:0] expectOf(int p);
    return N'(1) << p;
  endfunction

  task automatic check(string req, logic [N-1:0] act, logic [N-1:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: lights=%b expected=%b", req, act, exp);
    end
  endtask

  // Called at a falling edge with a valid model; returns at the next falling edge.
  task automatic applyMode(logic [1:0] m);
    string tag;
    sel = m;
    #1;
    check("R8", lights, expectOf(pos));  // mid-cycle change has no effect yet
    case (m)
      2'd2: begin tag = "R1"; pos = 0; end
      2'd1: begin tag = (pos == N-1) ? "R3" : "R2"; pos = (pos + 1) % N; end
      2'd0: begin tag = (pos == 0) ? "R5" : "R4"; pos = (pos + N - 1) % N; end
      default: tag = "R6";
    endcase
    @(negedge clk);
    check(tag, lights, expectOf(pos));
    testsRun++;
    if ($countones(lights) != 1) begin
      testsFailed++;
      $display("FAIL R7: lights=%b expected one bit set", lights);
    end
  endtask

  task automatic gotoPos(int p);
    applyMode(2'd2);
    for (int k = 0; k < p; k++) applyMode(2'd1);
  endtask

  initial begin
    logic [7:0] lfsr;
    // First clear: output is unknown before it, so no check until after.
    sel = 2'd2;
    @(negedge clk);
    pos = 0;
    check("R1", lights, 4'b0001);

    // Every start position against every mode.
    for (int p = 0; p < N; p++) begin
      for (int m = 0; m < 4; m++) begin
        gotoPos(p);
        applyMode(2'(m));
      end
    end

    // Full laps in each direction to cross both wraps repeatedly.
    applyMode(2'd2);
    for (int k = 0; k < 2 * N + 1; k++) applyMode(2'd1);
    for (int k = 0; k < 2 * N + 1; k++) applyMode(2'd0);
    for (int k = 0; k < 5; k++) applyMode(2'd3);

    // Deterministic pseudo-random mode stream.
    lfsr = 8'hA5;
    for (int k = 0; k < 300; k++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      applyMode(lfsr[1:0]);
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: run did not complete");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule